// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block owns the operating state of a serial peripheral core and turns it into enables for the core's data path. Software selects a state by writing a 2-bit code into a state register. It reads back the current code together with a settled flag. The flag is low while a change is still taking effect. A separate software-reset register brings the core back to its default state at any time, whatever the state of the handshake.

There are three visible states. In RESET the FIFOs and word counters are cleared. In RUN the shift engine moves data. In PAUSE the shift engine is frozen while the output FIFO can still be loaded. A fourth, internal state, PAUSE_ARMED, records that one clear code has arrived while paused. It reads back as PAUSE. Leaving PAUSE for RESET therefore takes two accepted writes of the clear code in a row.

The transitions are:
- RESET→RUN on code 1.
- RUN→PAUSE on code 3.
- PAUSE→RUN on code 1.
- PAUSE→PAUSE_ARMED on the first clear code (2).
- PAUSE_ARMED→RESET on the second clear code.
- PAUSE_ARMED→PAUSE on code 0 or 3.
- Any state→RESET on a software reset.

The usual transfer sequence is RESET, RUN, PAUSE while the output FIFO is preloaded, RUN again, and back to RESET when the transfer ends.

Top module: `periph_runstate_ctrl`

## Requirements
- R1: After the reset input is released, the state register reads code 0 with the settled flag at 1, and both fifo_flush and cnt_clear are high.
- R2: Reading the state register address (ADDR_STATE, default 0) returns the current code in bits [1:0], the settled flag in bit 2 and zero in every other bit. Every other address reads as zero.
- R3: An accepted write of code 1 or 3 from RESET or RUN enters RUN or PAUSE respectively. An accepted write of code 0 or 2 from RESET or RUN enters RESET. Each takes effect at the clock edge that samples the write.
- R4: Every state-register write accepted while the settled flag is 1 drives the flag low for exactly SETTLE_CYCLES clocks, after which it returns to 1.
- R5: A state-register write that arrives while the settled flag is 0 is ignored. Neither the code nor the settle window changes.
- R6: From PAUSE, a first accepted clear code (2) leaves the read code at 3. A second accepted clear code immediately after it enters RESET.
- R7: From PAUSE, an accepted code 0 leaves the code at 3. From PAUSE_ARMED, an accepted code 0 or 3 returns to plain PAUSE, so the next clear code only arms again. Code 1 from either PAUSE state enters RUN.
- R8: A write to ADDR_SWRST (default 1) with data bit 0 at 1 forces code 0 with the settled flag at 1 at the next edge, even while a window is open. With bit 0 at 0 it changes nothing.
- R9: The outputs depend only on the state. RESET drives fifo_flush and cnt_clear. RUN drives shift_en and ofifo_wr_ok. Both pause states drive hold and ofifo_wr_ok. Exactly one of fifo_flush, shift_en and hold is high.
- R10: The sequence RESET, RUN, PAUSE, RUN, then RESET through code 0 completes with the codes 1, 3, 1, 0 read back in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register (combinational) |
| fifo_flush | output | 1 | Flush the FIFOs (RESET) |
| cnt_clear | output | 1 | Clear the word counters (RESET) |
| shift_en | output | 1 | Shift engine enable (RUN) |
| hold | output | 1 | Freeze the shift engine (pause states) |
| ofifo_wr_ok | output | 1 | Output FIFO may be loaded (RUN and pause states) |

## Verification
The bench builds the block with DATA_W = 16 and SETTLE_CYCLES = 3. The short settle window means random writes often land both inside and outside it, so rejected writes and the exact rise of the settled flag come up many times. The narrower data word still covers the zero bits above the status field. Directed sequences cover the double clear, disarming from PAUSE_ARMED, and a software reset issued while a window is open.

// File: rtl/runstate_pkg.sv
package runstate_pkg;
    // Low two bits are the code read back by software.
    typedef enum logic [2:0] {
        RS_RESET       = 3'b000,
        RS_RUN         = 3'b001,
        RS_PAUSE       = 3'b011,
        RS_PAUSE_ARMED = 3'b111
    } rs_state_e;

    localparam logic [1:0] CODE_RESET = 2'd0;
    localparam logic [1:0] CODE_RUN   = 2'd1;
    localparam logic [1:0] CODE_CLEAR = 2'd2;
    localparam logic [1:0] CODE_PAUSE = 2'd3;
endpackage

// File: rtl/rs_reg_if.sv
module rs_reg_if #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 2,
    parameter int ADDR_STATE = 0,
    parameter int ADDR_SWRST = 1
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              settle_ok,
    input  logic [1:0]        cur_code,
    output logic              state_wr,
    output logic [1:0]        req_code,
    output logic              swrst,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int PAD_W = DATA_W - 3;

    logic sel_state, sel_swrst;
    logic unused_wdata;

    assign sel_state    = (reg_addr == ADDR_W'(ADDR_STATE));
    assign sel_swrst    = (reg_addr == ADDR_W'(ADDR_SWRST));
    assign state_wr     = reg_wr && sel_state;
    assign req_code     = reg_wdata[1:0];
    assign swrst        = reg_wr && sel_swrst && reg_wdata[0];
    assign unused_wdata = ^reg_wdata[DATA_W-1:2];

    always_comb begin
        reg_rdata = '0;
        if (sel_state)
            reg_rdata = {{PAD_W{1'b0}}, settle_ok, cur_code};
    end
endmodule

// File: rtl/rs_settle_timer.sv
module rs_settle_timer #(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic swrst,
    input  logic start,
    output logic settle_ok
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (swrst)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(SETTLE_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign settle_ok = (cnt_q == '0);
endmodule

// File: rtl/rs_state_fsm.sv
module rs_state_fsm
    import runstate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      swrst,
    input  logic      accept,
    input  logic [1:0] req_code,
    output rs_state_e state_q,
    output logic      fifo_flush,
    output logic      cnt_clear,
    output logic      shift_en,
    output logic      hold,
    output logic      ofifo_wr_ok
);
    rs_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (accept) begin
            unique case (state_q)
                RS_RESET, RS_RUN: begin
                    if (req_code == CODE_RUN)        state_d = RS_RUN;
                    else if (req_code == CODE_PAUSE) state_d = RS_PAUSE;
                    else                             state_d = RS_RESET;
                end
                RS_PAUSE: begin
                    if (req_code == CODE_CLEAR)    state_d = RS_PAUSE_ARMED;
                    else if (req_code == CODE_RUN) state_d = RS_RUN;
                    else                           state_d = RS_PAUSE;
                end
                RS_PAUSE_ARMED: begin
                    if (req_code == CODE_CLEAR)    state_d = RS_RESET;
                    else if (req_code == CODE_RUN) state_d = RS_RUN;
                    else                           state_d = RS_PAUSE;
                end
                default: state_d = RS_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RS_RESET;
        else if (swrst)
            state_q <= RS_RESET;
        else
            state_q <= state_d;
    end

    always_comb begin
        fifo_flush  = 1'b0;
        cnt_clear   = 1'b0;
        shift_en    = 1'b0;
        hold        = 1'b0;
        ofifo_wr_ok = 1'b0;
        unique case (state_q)
            RS_RESET: begin
                fifo_flush = 1'b1;
                cnt_clear  = 1'b1;
            end
            RS_RUN: begin
                shift_en    = 1'b1;
                ofifo_wr_ok = 1'b1;
            end
            RS_PAUSE, RS_PAUSE_ARMED: begin
                hold        = 1'b1;
                ofifo_wr_ok = 1'b1;
            end
            default: begin
                fifo_flush = 1'b1;
                cnt_clear  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/periph_runstate_ctrl.sv
module periph_runstate_ctrl
    import runstate_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 2,
    parameter int ADDR_STATE    = 0,
    parameter int ADDR_SWRST    = 1,
    parameter int SETTLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              fifo_flush,
    output logic              cnt_clear,
    output logic              shift_en,
    output logic              hold,
    output logic              ofifo_wr_ok
);
    rs_state_e  state_q;
    logic       settle_ok;
    logic       state_wr;
    logic       accept;
    logic       swrst;
    logic [1:0] req_code;

    assign accept = state_wr && settle_ok;

    rs_reg_if #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .ADDR_STATE(ADDR_STATE), .ADDR_SWRST(ADDR_SWRST)
    ) u_reg_if (
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .settle_ok(settle_ok), .cur_code(state_q[1:0]),
        .state_wr(state_wr), .req_code(req_code), .swrst(swrst),
        .reg_rdata(reg_rdata)
    );

    rs_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .swrst(swrst), .start(accept),
        .settle_ok(settle_ok)
    );

    rs_state_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .swrst(swrst), .accept(accept),
        .req_code(req_code), .state_q(state_q),
        .fifo_flush(fifo_flush), .cnt_clear(cnt_clear),
        .shift_en(shift_en), .hold(hold), .ofifo_wr_ok(ofifo_wr_ok)
    );
endmodule

// File: rtl/rs_checker.sv
module rs_checker
    import runstate_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int ADDR_STATE = 0,
    parameter int ADDR_SWRST = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        wdata_lo,
    input rs_state_e         state_q,
    input logic              settle_ok,
    input logic              fifo_flush,
    input logic              shift_en,
    input logic              hold
);
    logic st_wr, sw_wr;
    assign st_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_STATE));
    assign sw_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_SWRST)) && wdata_lo[0];

    a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && settle_ok) |=> !settle_ok);

    a_r5_stable_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!settle_ok && !sw_wr) |=> $stable(state_q));

    a_r6_first_clear_keeps_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && settle_ok && !sw_wr && state_q == RS_PAUSE && wdata_lo == CODE_CLEAR)
        |=> (state_q[1:0] == CODE_PAUSE));

    a_r8_swrst_restores: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (state_q == RS_RESET && settle_ok));

    a_r9_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fifo_flush, shift_en, hold}) == 1);
endmodule

bind periph_runstate_ctrl rs_checker #(
    .ADDR_W(ADDR_W), .ADDR_STATE(ADDR_STATE), .ADDR_SWRST(ADDR_SWRST)
) u_rs_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wdata_lo(reg_wdata[1:0]), .state_q(state_q), .settle_ok(settle_ok),
    .fifo_flush(fifo_flush), .shift_en(shift_en), .hold(hold)
);

// File: tb/periph_runstate_ctrl_bench.sv
module periph_runstate_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int AW         = 2;
    localparam int SETTLE     = 3;
    localparam logic [AW-1:0] A_ST = 2'd0;
    localparam logic [AW-1:0] A_SW = 2'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic fifo_flush, cnt_clear, shift_en, hold, ofifo_wr_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // model: 0 reset, 1 run, 3 pause, 4 pause armed
    int m_st  = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_runstate_ctrl #(
        .DATA_W(DW), .ADDR_W(AW), .ADDR_STATE(0), .ADDR_SWRST(1),
        .SETTLE_CYCLES(SETTLE)
    ) u_periph_runstate_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_flush(fifo_flush), .cnt_clear(cnt_clear), .shift_en(shift_en),
        .hold(hold), .ofifo_wr_ok(ofifo_wr_ok)
    );

    function automatic int next_st(input int s, input int c);
        if (s == 0 || s == 1) return (c == 1) ? 1 : (c == 3) ? 3 : 0;
        if (s == 3)           return (c == 2) ? 4 : (c == 1) ? 1 : 3;
        return (c == 2) ? 0 : (c == 1) ? 1 : 3;
    endfunction

    function automatic int vis_code(input int s);
        return (s == 4) ? 3 : s;
    endfunction

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [DW-1:0] e_rd;
        bit rs, rn, ps;
        e_rd = '0;
        if (reg_addr == A_ST) e_rd = DW'({(m_cnt == 0), 2'(vis_code(m_st))});
        chk(cur_tag, "rdata", reg_rdata, e_rd);
        rs = (m_st == 0); rn = (m_st == 1); ps = (m_st >= 3);
        chk("R9", "outputs", DW'({fifo_flush, cnt_clear, shift_en, hold, ofifo_wr_ok}),
            DW'({rs, rs, rn, ps, rn | ps}));
    endtask

    task automatic cyc(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (w && a == A_SW && d[0]) begin
            m_st = 0; m_cnt = 0;
        end else if (w && a == A_ST && m_cnt == 0) begin
            m_st = next_st(m_st, int'(d[1:0])); m_cnt = SETTLE;
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        #1;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, A_ST, '0);
    endtask

    task automatic put(input int code);
        cyc(1'b1, A_ST, DW'(code));
        idle(SETTLE);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_tag = "R1"; idle(2);
        cur_tag = "R2"; cyc(1'b0, 2'd2, '0); cyc(1'b0, 2'd3, '0); cyc(1'b0, A_SW, '0);
        // R10 full sequence, R3 direct entries, R4 window timing
        cur_tag = "R10"; put(1); put(3); put(1); put(0);
        cur_tag = "R3"; put(3); put(2); put(1); put(2);
        cur_tag = "R4"; cyc(1'b1, A_ST, 16'h0001); idle(SETTLE + 2);
        // R5: writes inside the window are dropped
        cur_tag = "R5"; cyc(1'b1, A_ST, 16'h0003); cyc(1'b1, A_ST, 16'h0000);
        cyc(1'b1, A_ST, 16'h0002); idle(SETTLE);
        // R6: double clear from pause
        cur_tag = "R6"; put(3); put(2); put(2);
        // R7: disarm and code 0 from pause
        cur_tag = "R7"; put(1); put(3); put(0); put(2); put(3); put(2); put(0); put(2);
        put(1); put(3); put(2); put(1);
        // R8: software reset during a window, and with bit 0 clear
        cur_tag = "R8"; cyc(1'b1, A_ST, 16'h0003); cyc(1'b1, A_SW, 16'h0001); idle(1);
        put(1); cyc(1'b1, A_SW, 16'hFFFE); idle(2);
        cyc(1'b1, A_SW, 16'h0003); idle(1);
        // random mix
        cur_tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            bit w;
            logic [AW-1:0] a;
            int r;
            w = ($urandom % 2) == 0;
            r = $urandom % 16;
            a = (r == 0) ? A_SW : (r == 1) ? 2'd2 : (r == 2) ? 2'd3 : A_ST;
            cyc(w, a, DW'($urandom));
        end
        finish_run();
    end
endmodule